// File: doc/BRIEF.md
# CAN Transmit Mailbox Scheduler

This block holds three outgoing CAN frames on the register side of a controller and decides which one is offered next to the frame sender. For each slot, software writes three words while the slot is empty: a length/property word and two data words. It then writes the identifier word with its request bit set. From that point the slot belongs to the block. The block picks one pending slot at a time and presents that slot's fields to a simplified sender. The sender reports the outcome with a one-cycle pulse: done, error or arbitration lost.

Each slot has three status bits: empty, finished and finished-without-error. Together they tell software whether the slot is pending, failed or succeeded. Software can abort a slot and clear finished flags by writing 1. It can choose the next slot either by identifier priority or by request order, and it can turn off automatic retransmission. A time-triggered enable sets or clears the time-stamp bit of every slot. An interrupt line reports finished slots when its enable is set.

Top module: `can_tx_mailbox`

## Requirements
- R1: After reset, `empty` reads 3'b111, `fin` and `ok` read 0, and `tx_req` and `irq` are low.
- R2: Writing the identifier word (`wr_sel`=0) with bit 0 set to an empty slot makes that slot pending at the next edge. Pending means its `empty`, `fin` and `ok` bits all clear. While no frame is in flight, `tx_req` rises one edge later. Writes of any word to a slot that is not empty are ignored.
- R3: While `tx_req` is high, the outputs present the chosen slot's fields. `tx_ident` is the identifier word. `tx_len` is bits 3:0 of the property word (`wr_sel`=1). `tx_data` carries the first data word (`wr_sel`=2) in bits 31:0 and the second (`wr_sel`=3) in bits 63:32, so byte k sits at bits 8k+7:8k.
- R4: With `order_mode`=0 the pending slot with the smallest priority key goes next. For a standard frame (bit 2 clear) the key is the 11-bit identifier in bits 31:21. For an extended frame the key is the 29-bit identifier in bits 31:3. On equal keys the lower slot number wins.
- R5: With `order_mode`=1 pending slots go in the order their requests were written.
- R6: A `tx_done` pulse while `tx_req` is high sets that slot's `fin`, `ok` and `empty` at the same edge and drops `tx_req`.
- R7: With `no_retx`=0, an error or arbitration-lost pulse leaves the slot pending with `fin` clear. `tx_req` is low for one cycle and the slot is then offered again.
- R8: With `no_retx`=1, an error or arbitration-lost pulse ends the slot as failed (`fin`=1, `ok`=0, `empty`=1) with no retry.
- R9: Aborting a pending slot that is not in flight makes it failed at the next edge. Aborting the slot in flight lets it finish: it succeeds on done and fails on error or arbitration loss, without retry. Aborting an empty slot has no effect.
- R10: Writing 1 to `clr_fin[i]` clears `fin[i]` and `ok[i]`. If the slot completes at the same edge, the completion wins.
- R11: `irq` is high exactly while `irq_en` is 1 and any `fin` bit is set.
- R12: A rising edge of `ttm_en` sets the time-stamp bit (property word bit 8) in all three slots, and a falling edge clears it in all three. `tx_tsen` shows the bit of the slot in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_slot | input | 2 | Slot addressed by the write |
| wr_sel | input | 2 | Word select: 0 identifier, 1 property, 2 data low, 3 data high |
| wr_data | input | 32 | Write data |
| abort_req | input | 3 | Per-slot abort pulse |
| clr_fin | input | 3 | Per-slot write-1-to-clear of finished status |
| order_mode | input | 1 | 0 identifier priority, 1 request order |
| no_retx | input | 1 | Disable automatic retransmission |
| ttm_en | input | 1 | Time-triggered mode enable |
| irq_en | input | 1 | Transmit-finished interrupt enable |
| empty | output | 3 | Per-slot empty status |
| fin | output | 3 | Per-slot finished status |
| ok | output | 3 | Per-slot finished-without-error status |
| irq | output | 1 | Interrupt request |
| tx_req | output | 1 | Frame offered to the sender |
| tx_slot | output | 2 | Slot in flight |
| tx_ident | output | 32 | Identifier word of the slot in flight |
| tx_len | output | 4 | Length code of the slot in flight |
| tx_tsen | output | 1 | Time-stamp bit of the slot in flight |
| tx_data | output | 64 | Data bytes of the slot in flight |
| tx_done | input | 1 | Sender pulse: frame sent |
| tx_err | input | 1 | Sender pulse: error |
| tx_arb_lost | input | 1 | Sender pulse: arbitration lost |

## Verification
Two pairs of events can land on the same edge. The first is a software clear of a finished flag together with the sender's completion of that same slot. The bench drives `tx_done` and `clr_fin` in the same cycle and expects `fin` and `ok` to stay set. The second is an abort together with the slot being in flight. The bench aborts the launched slot, then pulses arbitration loss with retransmission enabled, and expects a failed slot and no relaunch. It also aborts a queued slot while another is in flight and expects only the queued slot to fail.

// File: rtl/can_tx_mailbox.sv
module can_tx_mailbox (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_slot,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [2:0]  abort_req,
  input  logic [2:0]  clr_fin,
  input  logic        order_mode,
  input  logic        no_retx,
  input  logic        ttm_en,
  input  logic        irq_en,
  output logic [2:0]  empty,
  output logic [2:0]  fin,
  output logic [2:0]  ok,
  output logic        irq,
  output logic        tx_req,
  output logic [1:0]  tx_slot,
  output logic [31:0] tx_ident,
  output logic [3:0]  tx_len,
  output logic        tx_tsen,
  output logic [63:0] tx_data,
  input  logic        tx_done,
  input  logic        tx_err,
  input  logic        tx_arb_lost
);
  localparam int NS = 3;

  logic [31:0] ident [NS];
  logic [31:0] dlo   [NS];
  logic [31:0] dhi   [NS];
  logic [3:0]  len   [NS];
  logic [1:0]  rank  [NS];
  logic [1:0]  nrank [NS];
  logic [NS-1:0] tsen, pend, hold;
  logic [NS-1:0] cand, cancel, leave, stay, newreq, wr_ok;
  logic        busy, ttm_q, found;
  logic [1:0]  cur, sel;
  logic        fire, final_c;

  function automatic logic [28:0] prio_key(input logic [31:0] w);
    return w[2] ? w[31:3] : {w[31:21], 18'd0};
  endfunction

  assign fire    = busy & (tx_done | tx_err | tx_arb_lost);
  assign final_c = fire & (tx_done | no_retx | hold[cur]);
  assign cand    = busy ? '0 : (pend & ~abort_req);

  always_comb begin
    for (int i = 0; i < NS; i++) begin
      wr_ok[i]  = wr_en && wr_slot == 2'(i) && !pend[i];
      newreq[i] = wr_ok[i] && wr_sel == 2'd0 && wr_data[0];
      cancel[i] = abort_req[i] && pend[i] && !(busy && cur == 2'(i));
      leave[i]  = cancel[i] || (final_c && cur == 2'(i));
      stay[i]   = pend[i] && !leave[i];
    end
  end

  // new rank = number of surviving requests older than this one
  always_comb begin
    for (int i = 0; i < NS; i++) begin
      nrank[i] = 2'd0;
      for (int j = 0; j < NS; j++) begin
        if (j != i && stay[j] && (newreq[i] || (stay[i] && rank[j] < rank[i])))
          nrank[i] = nrank[i] + 2'd1;
      end
    end
  end

  always_comb begin
    sel   = 2'd0;
    found = 1'b0;
    for (int i = 0; i < NS; i++) begin
      if (cand[i] && (!found || (order_mode ? rank[i] < rank[sel]
                                             : prio_key(ident[i]) < prio_key(ident[sel])))) begin
        sel   = 2'(i);
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cur   <= 2'd0;
      ttm_q <= 1'b0;
      pend  <= '0;
      fin   <= '0;
      ok    <= '0;
      hold  <= '0;
      tsen  <= '0;
      for (int i = 0; i < NS; i++) begin
        ident[i] <= '0;
        dlo[i]   <= '0;
        dhi[i]   <= '0;
        len[i]   <= '0;
        rank[i]  <= '0;
      end
    end else begin
      ttm_q <= ttm_en;
      for (int i = 0; i < NS; i++) begin
        rank[i] <= nrank[i];
        if (wr_ok[i]) begin
          case (wr_sel)
            2'd0: ident[i] <= wr_data;
            2'd1: begin len[i] <= wr_data[3:0]; tsen[i] <= wr_data[8]; end
            2'd2: dlo[i] <= wr_data;
            default: dhi[i] <= wr_data;
          endcase
        end
        if (ttm_en && !ttm_q)      tsen[i] <= 1'b1;
        else if (!ttm_en && ttm_q) tsen[i] <= 1'b0;

        if (newreq[i])     pend[i] <= 1'b1;
        else if (leave[i]) pend[i] <= 1'b0;

        if (newreq[i]) begin
          fin[i] <= 1'b0; ok[i] <= 1'b0;
        end else if (cancel[i]) begin
          fin[i] <= 1'b1; ok[i] <= 1'b0;
        end else if (final_c && cur == 2'(i)) begin
          fin[i] <= 1'b1; ok[i] <= tx_done;
        end else if (clr_fin[i]) begin
          fin[i] <= 1'b0; ok[i] <= 1'b0;
        end

        if (leave[i]) hold[i] <= 1'b0;
        else if (abort_req[i] && pend[i] && busy && cur == 2'(i)) hold[i] <= 1'b1;
      end
      if (fire) busy <= 1'b0;
      else if (|cand) begin
        busy <= 1'b1;
        cur  <= sel;
      end
    end
  end

  assign empty    = ~pend;
  assign irq      = irq_en & (|fin);
  assign tx_req   = busy;
  assign tx_slot  = cur;
  assign tx_ident = ident[cur];
  assign tx_len   = len[cur];
  assign tx_tsen  = tsen[cur];
  assign tx_data  = {dhi[cur], dlo[cur]};

  assert_inflight_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> !empty[tx_slot]);

  assert_done_success_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && tx_done |=> fin[$past(tx_slot)] && ok[$past(tx_slot)] && empty[$past(tx_slot)] && !tx_req);

  assert_no_retry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && !tx_done && (tx_err || tx_arb_lost) && no_retx
    |=> fin[$past(tx_slot)] && !ok[$past(tx_slot)] && empty[$past(tx_slot)]);

  assert_retry_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && !tx_done && tx_arb_lost && !no_retx && !hold[tx_slot] && !abort_req[tx_slot]
    |=> !empty[$past(tx_slot)] && !fin[$past(tx_slot)] && !tx_req);

  for (genvar g = 0; g < NS; g++) begin : g_chk
    assert_abort_fails_R9: assert property (@(posedge clk) disable iff (!rst_n)
      abort_req[g] && !empty[g] && !(tx_req && tx_slot == 2'(g))
      |=> fin[g] && !ok[g] && empty[g]);
  end
endmodule

// File: tb/tb_can_tx_mailbox.sv
module tb_can_tx_mailbox;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0; logic [1:0] wr_slot = 0, wr_sel = 0; logic [31:0] wr_data = 0;
  logic [2:0] abort_req = 0, clr_fin = 0;
  logic order_mode = 0, no_retx = 0, ttm_en = 0, irq_en = 0;
  logic [2:0] empty, fin, ok;
  logic irq, tx_req, tx_tsen;
  logic [1:0] tx_slot;
  logic [31:0] tx_ident;
  logic [3:0] tx_len;
  logic [63:0] tx_data;
  logic tx_done = 0, tx_err = 0, tx_arb_lost = 0;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  can_tx_mailbox dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(wr_slot), .wr_sel(wr_sel),
    .wr_data(wr_data), .abort_req(abort_req), .clr_fin(clr_fin), .order_mode(order_mode),
    .no_retx(no_retx), .ttm_en(ttm_en), .irq_en(irq_en), .empty(empty), .fin(fin), .ok(ok),
    .irq(irq), .tx_req(tx_req), .tx_slot(tx_slot), .tx_ident(tx_ident), .tx_len(tx_len),
    .tx_tsen(tx_tsen), .tx_data(tx_data), .tx_done(tx_done), .tx_err(tx_err),
    .tx_arb_lost(tx_arb_lost));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int s, input int w, input logic [31:0] d);
    wr_en = 1; wr_slot = 2'(s); wr_sel = 2'(w); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic req(input int s, input logic [10:0] id);
    wr(s, 0, {id, 21'd1});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int kind);
    tx_done = (kind == 0); tx_err = (kind == 1); tx_arb_lost = (kind == 2);
    @(negedge clk);
    tx_done = 0; tx_err = 0; tx_arb_lost = 0;
  endtask

  task automatic clear_all();
    clr_fin = 3'b111; @(negedge clk); clr_fin = 0;
  endtask

  task automatic t_reset();
    chk("R1 empty", 64'(empty), 64'h7);
    chk("R1 fin/ok", 64'({fin, ok}), 64'h0);
    chk("R1 req/irq", 64'({tx_req, irq}), 64'h0);
  endtask

  task automatic t_basic();
    wr(1, 1, 32'h5); wr(1, 2, 32'h44332211); wr(1, 3, 32'h88776655);
    req(1, 11'h123);
    chk("R2 pending", 64'({empty, fin[1], ok[1], tx_req}), 64'({3'b101, 3'b000}));
    idle(1);
    chk("R2 launch", 64'({tx_req, tx_slot}), 64'({1'b1, 2'd1}));
    chk("R3 ident", 64'(tx_ident), 64'({11'h123, 21'd1}));
    chk("R3 len", 64'(tx_len), 64'h5);
    chk("R3 data", tx_data, 64'h8877665544332211);
    wr(1, 0, 32'hFFFF_FFF1);
    wr(1, 2, 32'h0);
    chk("R2 ignored write", 64'({tx_ident, tx_data[31:0]}), 64'({11'h123, 21'd1, 32'h44332211}));
    pulse(0);
    chk("R6 success", 64'({fin, ok, empty, tx_req}), 64'({3'b010, 3'b010, 3'b111, 1'b0}));
    chk("R11 irq disabled", 64'(irq), 64'h0);
    irq_en = 1; #1;
    chk("R11 irq enabled", 64'(irq), 64'h1);
    @(negedge clk);
    clr_fin = 3'b010; @(negedge clk); clr_fin = 0;
    chk("R10 clear", 64'({fin, ok, irq}), 64'h0);
    irq_en = 0;
  endtask

  task automatic t_prio();
    req(0, 11'h700); req(2, 11'h100); req(1, 11'h200);
    chk("R4 first", 64'(tx_slot), 64'd0);
    pulse(0); idle(1);
    chk("R4 lowest id", 64'({tx_req, tx_slot}), 64'({1'b1, 2'd2}));
    pulse(0); idle(1);
    chk("R4 next id", 64'({tx_req, tx_slot}), 64'({1'b1, 2'd1}));
    pulse(0); clear_all();
    req(0, 11'h700); req(2, 11'h055); req(1, 11'h055);
    pulse(0); idle(1);
    chk("R4 tie lower slot", 64'(tx_slot), 64'd1);
    pulse(0); idle(1);
    chk("R4 tie second", 64'(tx_slot), 64'd2);
    pulse(0); clear_all();
  endtask

  task automatic t_order();
    order_mode = 1;
    req(0, 11'h700); req(1, 11'h300); req(2, 11'h100);
    pulse(0); idle(1);
    chk("R5 oldest first", 64'(tx_slot), 64'd1);
    pulse(0); idle(1);
    chk("R5 then next", 64'(tx_slot), 64'd2);
    pulse(0); clear_all();
    order_mode = 0;
  endtask

  task automatic t_retry();
    req(0, 11'h123); idle(1);
    pulse(2);
    chk("R7 arb lost stays", 64'({tx_req, empty[0], fin[0]}), 64'h0);
    idle(1);
    chk("R7 relaunch", 64'({tx_req, tx_slot}), 64'({1'b1, 2'd0}));
    pulse(1);
    chk("R7 error stays", 64'({tx_req, empty[0]}), 64'h0);
    idle(1);
    chk("R7 relaunch err", 64'(tx_req), 64'h1);
    pulse(0);
    chk("R7 final success", 64'({fin[0], ok[0]}), 64'h3);
    clear_all();
  endtask

  task automatic t_noretx();
    no_retx = 1;
    req(0, 11'h123); idle(1);
    pulse(1);
    chk("R8 failed", 64'({fin[0], ok[0], empty[0], tx_req}), 64'({4'b1010}));
    idle(1);
    chk("R8 no retry", 64'(tx_req), 64'h0);
    clear_all();
    req(2, 11'h010); idle(1);
    pulse(2);
    chk("R8 arb failed", 64'({fin[2], ok[2], empty[2]}), 64'({3'b101}));
    clear_all();
    no_retx = 0;
  endtask

  task automatic t_abort();
    req(0, 11'h123); req(1, 11'h124);
    abort_req = 3'b010; @(negedge clk); abort_req = 0;
    chk("R9 abort queued", 64'({fin[1], ok[1], empty[1]}), 64'({3'b101}));
    chk("R9 inflight untouched", 64'({tx_req, tx_slot}), 64'({1'b1, 2'd0}));
    abort_req = 3'b100; @(negedge clk); abort_req = 0;
    chk("R9 abort empty ignored", 64'({fin[2], empty[2]}), 64'({2'b01}));
    abort_req = 3'b001; @(negedge clk); abort_req = 0;
    chk("R9 abort inflight waits", 64'({tx_req, empty[0]}), 64'({2'b10}));
    pulse(2);
    chk("R9 aborted fails", 64'({fin[0], ok[0], empty[0]}), 64'({3'b101}));
    idle(1);
    chk("R9 no relaunch", 64'(tx_req), 64'h0);
    clear_all();
  endtask

  task automatic t_collide();
    req(0, 11'h321); idle(1);
    tx_done = 1; clr_fin = 3'b001;
    @(negedge clk);
    tx_done = 0; clr_fin = 0;
    chk("R10 completion wins", 64'({fin[0], ok[0]}), 64'h3);
    clear_all();
  endtask

  task automatic t_tsen();
    wr(2, 1, 32'h3);
    ttm_en = 1; idle(1);
    req(2, 11'h050); idle(1);
    chk("R12 set on rise", 64'({tx_tsen, tx_len}), 64'({1'b1, 4'h3}));
    pulse(0); clear_all();
    ttm_en = 0; idle(1);
    req(2, 11'h050); idle(1);
    chk("R12 clear on fall", 64'(tx_tsen), 64'h0);
    pulse(0); clear_all();
    wr(1, 1, 32'h104); req(1, 11'h051); idle(1);
    chk("R12 written bit", 64'({tx_tsen, tx_len}), 64'({1'b1, 4'h4}));
    pulse(0); clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_prio();
    t_order();
    t_retry();
    t_noretx();
    t_abort();
    t_collide();
    t_tsen();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule